// File: doc/BRIEF.md
# Serial Instruction Clock Pulse Guard

This block protects a serial-access non-volatile memory from instructions that arrive misaligned because of clock noise. An extra or missing serial clock edge shifts every later address and data bit by one position. The block counts the serial clock rising edges in one chip-select session. Counting begins with the edge that samples the start bit. When chip select falls, the block compares the total with the exact length the decoded instruction needs in the current organization.

Instructions that change the array are writing one location, erasing one location, erasing everything and writing everything. For these, a mismatch produces an abort verdict, and the programming sequencer must then leave the array untouched. Instructions that do not modify the array always receive a commit verdict. The decoder supplies the opcode and the two extended-opcode bits, which are the leading address bits. The opcode and the extended-opcode bits must be stable when chip select falls. All inputs are synchronous to the system clock. The serial clock arrives as a one-cycle rising-edge strobe.

Top module: `clk_pulse_guard`

## Requirements
- R1: After synchronous reset both verdict outputs are low and no session is armed.
- R2: The count starts at 1 on the strobe cycle where the start bit is flagged while chip select is high. Strobes that arrive before the start bit is flagged do not count. A later start flag in the same session does not restart the count. The count returns to zero on every chip-select rising edge.
- R3: In byte organization (org_x16 = 0), the opcode values are 01 for single write, 11 for single erase, 10 for read and 00 for the extended group. In the extended group, ext_op 01 means write-all, 10 means erase-all, 11 means enable and 00 means disable. Single write and write-all expect 18 pulses. Single erase and erase-all expect 10 pulses.
- R4: In word organization (org_x16 = 1), single write and write-all expect 25 pulses. Single erase and erase-all expect 9 pulses.
- R5: An armed session produces one verdict. The verdict appears one clock after the first cycle in which chip select is seen low. A modifying instruction gets commit when the count equals its expected length and abort when it does not.
- R6: Read, enable and disable always receive commit, whatever the pulse count.
- R7: A write with one pulse fewer or one pulse more than expected receives abort.
- R8: A strobe in the same cycle in which chip select is first seen low is not counted.
- R9: The count saturates at its all-ones value and never wraps. A word-organization write with 57 pulses therefore receives abort, even though 57 aliases to 25 in a 5-bit counter.
- R10: Commit and abort are never high together and never high for two consecutive cycles. A session with no start bit produces no verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| cs | input | 1 | Chip select level, synchronous to clk |
| start_bit | input | 1 | Start bit sampled on this strobe |
| opcode | input | 2 | Decoded two-bit opcode |
| ext_op | input | 2 | Extended-opcode bits (leading address bits) |
| org_x16 | input | 1 | 1 selects word organization, 0 byte |
| commit | output | 1 | One-cycle pulse: instruction may proceed |
| abort | output | 1 | One-cycle pulse: modifying instruction vetoed |

## Verification
Counting and verdict evaluation can fall in the same cycle when a serial clock strobe arrives in the cycle where chip select is first seen low. The bench provokes this with a byte write of exactly 18 pulses whose closing strobe coincides with the chip-select drop. The verdict must be commit, which shows that the coincident edge was excluded. Counting the edge would give 19 pulses and an abort.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_DIS  = 2'b00,
    EX_WRAL = 2'b01,
    EX_ERAL = 2'b10,
    EX_EN   = 2'b11
  } ext_e;
endpackage

// File: rtl/cpg_cs_edge.sv
module cpg_cs_edge (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  output logic cs_rise,
  output logic cs_fall
);
  logic cs_q;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b0;
    else     cs_q <= cs;
  end

  assign cs_rise = cs & ~cs_q;
  assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/cpg_counter.sv
module cpg_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs,
  input  logic             cs_rise,
  input  logic             cs_fall,
  input  logic             sclk_rise,
  input  logic             start_bit,
  output logic [CNT_W-1:0] cnt,
  output logic             armed
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic load, inc;

  assign load = cs & sclk_rise & start_bit & ~armed;
  assign inc  = cs & sclk_rise & armed & (cnt != SAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (load)         cnt <= CNT_W'(1);
      else if (cs_rise) cnt <= '0;
      else if (inc)     cnt <= cnt + CNT_W'(1);

      if (load)                   armed <= 1'b1;
      else if (cs_rise | cs_fall) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/cpg_len_table.sv
module cpg_len_table
  import cpg_pkg::*;
#(
  parameter int ADDR_W16 = 6,
  parameter int DATA_W16 = 16,
  parameter int CNT_W    = 5
) (
  input  logic [1:0]       opcode,
  input  logic [1:0]       ext_op,
  input  logic             org_x16,
  output logic [CNT_W-1:0] exp_len,
  output logic             modifies
);
  localparam int HDR = 3;

  logic [CNT_W-1:0] short_len [2];
  logic [CNT_W-1:0] long_len  [2];

  for (genvar g = 0; g < 2; g++) begin : g_org
    localparam int AW = (g == 1) ? ADDR_W16 : ADDR_W16 + 1;
    localparam int DW = (g == 1) ? DATA_W16 : DATA_W16 / 2;
    assign short_len[g] = CNT_W'(HDR + AW);
    assign long_len[g]  = CNT_W'(HDR + AW + DW);
  end

  logic has_data;

  always_comb begin
    has_data = (opcode == OP_WRITE) || (opcode == OP_EXT && ext_op == EX_WRAL);
    modifies = (opcode == OP_WRITE) || (opcode == OP_ERASE) ||
               (opcode == OP_EXT && (ext_op == EX_WRAL || ext_op == EX_ERAL));
    exp_len  = has_data ? long_len[org_x16] : short_len[org_x16];
  end
endmodule

// File: rtl/clk_pulse_guard.sv
module clk_pulse_guard #(
  parameter int ADDR_W16 = 6,
  parameter int DATA_W16 = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk_rise,
  input  logic       cs,
  input  logic       start_bit,
  input  logic [1:0] opcode,
  input  logic [1:0] ext_op,
  input  logic       org_x16,
  output logic       commit,
  output logic       abort
);
  localparam int MAX_LEN = 3 + ADDR_W16 + DATA_W16;
  localparam int CNT_W   = $clog2(MAX_LEN + 2);

  logic             cs_rise, cs_fall, armed, modifies, match;
  logic [CNT_W-1:0] cnt, exp_len;

  cpg_cs_edge u_edge (
    .clk(clk), .rst(rst), .cs(cs), .cs_rise(cs_rise), .cs_fall(cs_fall)
  );

  cpg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .cs(cs), .cs_rise(cs_rise), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .start_bit(start_bit), .cnt(cnt), .armed(armed)
  );

  cpg_len_table #(.ADDR_W16(ADDR_W16), .DATA_W16(DATA_W16), .CNT_W(CNT_W)) u_len (
    .opcode(opcode), .ext_op(ext_op), .org_x16(org_x16),
    .exp_len(exp_len), .modifies(modifies)
  );

  assign match = (cnt == exp_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      commit <= 1'b0;
      abort  <= 1'b0;
    end else begin
      commit <= cs_fall & armed & (~modifies | match);
      abort  <= cs_fall & armed & modifies & ~match;
    end
  end
endmodule

// File: rtl/cpg_chk.sv
module cpg_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cs,
  input logic [1:0]       opcode,
  input logic [1:0]       ext_op,
  input logic             commit,
  input logic             abort,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] SAT = '1;

  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(commit && abort));

  p_commit_single_r10: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  p_abort_single_r10: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);

  p_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
    (commit || abort) |-> (!$past(cs) && $past(cs, 2)));

  p_nonmod_commit_r6: assert property (@(posedge clk) disable iff (rst)
    abort |-> !($past(opcode) == 2'b10 ||
                ($past(opcode) == 2'b00 &&
                 ($past(ext_op) == 2'b11 || $past(ext_op) == 2'b00))));

  p_no_count_low_r8: assert property (@(posedge clk) disable iff (rst)
    !cs |=> $stable(cnt));

  p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && cs && cnt == SAT) |=> (cnt == SAT));
endmodule

bind clk_pulse_guard cpg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .opcode(opcode), .ext_op(ext_op),
  .commit(commit), .abort(abort), .armed(armed), .cnt(cnt)
);

// File: tb/clk_pulse_guard_tb.sv
module clk_pulse_guard_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sclk_rise = 1'b0;
  logic       cs = 1'b0;
  logic       start_bit = 1'b0;
  logic [1:0] opcode = 2'b10;
  logic [1:0] ext_op = 2'b00;
  logic       org_x16 = 1'b0;
  logic       commit, abort;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clk_pulse_guard u_dut (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .cs(cs), .start_bit(start_bit),
    .opcode(opcode), .ext_op(ext_op), .org_x16(org_x16),
    .commit(commit), .abort(abort)
  );

  task automatic check2(string req, string what, logic c, logic a, logic ec, logic ea);
    checks++;
    if (c !== ec || a !== ea) begin
      errors++;
      $display("FAIL %s %s: commit/abort actual %b%b expected %b%b", req, what, c, a, ec, ea);
    end
  endtask

  task automatic pulse(bit st);
    sclk_rise = 1'b1; start_bit = st;
    @(negedge clk);
    sclk_rise = 1'b0; start_bit = 1'b0;
    @(negedge clk);
  endtask

  // exp: 0 none, 1 commit, 2 abort
  task automatic session(string req, bit org, logic [1:0] op, logic [1:0] ex,
                         int pre, bit with_start, int n, bit collide, int exp);
    @(negedge clk);
    cs = 1'b1; org_x16 = org; opcode = op; ext_op = ex;
    @(negedge clk);
    for (int i = 0; i < pre; i++) pulse(1'b0);
    if (with_start) begin
      pulse(1'b1);
      for (int i = 1; i < n; i++) pulse(1'b0);
    end else begin
      for (int i = 0; i < n; i++) pulse(1'b0);
    end
    cs = 1'b0; sclk_rise = collide;
    @(negedge clk);
    sclk_rise = 1'b0;
    check2(req, "verdict", commit, abort, exp == 1, exp == 2);
    @(negedge clk);
    check2(req, "single pulse", commit, abort, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check2("R1", "reset", commit, abort, 1'b0, 1'b0);
  endtask

  task automatic t_byte_lengths;
    session("R3 write18", 1'b0, 2'b01, 2'b00, 0, 1'b1, 18, 1'b0, 1);
    session("R3 wral18",  1'b0, 2'b00, 2'b01, 0, 1'b1, 18, 1'b0, 1);
    session("R3 erase10", 1'b0, 2'b11, 2'b00, 0, 1'b1, 10, 1'b0, 1);
    session("R3 eral10",  1'b0, 2'b00, 2'b10, 0, 1'b1, 10, 1'b0, 1);
    session("R3 erase11", 1'b0, 2'b11, 2'b00, 0, 1'b1, 11, 1'b0, 2);
  endtask

  task automatic t_word_lengths;
    session("R4 write25", 1'b1, 2'b01, 2'b00, 0, 1'b1, 25, 1'b0, 1);
    session("R4 wral25",  1'b1, 2'b00, 2'b01, 0, 1'b1, 25, 1'b0, 1);
    session("R4 erase9",  1'b1, 2'b11, 2'b00, 0, 1'b1, 9,  1'b0, 1);
    session("R4 eral10",  1'b1, 2'b00, 2'b10, 0, 1'b1, 10, 1'b0, 2);
  endtask

  task automatic t_misaligned;
    session("R7 write17", 1'b0, 2'b01, 2'b00, 0, 1'b1, 17, 1'b0, 2);
    session("R7 write19", 1'b0, 2'b01, 2'b00, 0, 1'b1, 19, 1'b0, 2);
    session("R5 glitch26", 1'b1, 2'b01, 2'b00, 0, 1'b1, 26, 1'b0, 2);
  endtask

  task automatic t_nonmod;
    session("R6 read5",  1'b0, 2'b10, 2'b00, 0, 1'b1, 5,  1'b0, 1);
    session("R6 en3",    1'b0, 2'b00, 2'b11, 0, 1'b1, 3,  1'b0, 1);
    session("R6 dis40",  1'b1, 2'b00, 2'b00, 0, 1'b1, 40, 1'b0, 1);
  endtask

  task automatic t_start_and_collide;
    session("R2 prezeros", 1'b0, 2'b01, 2'b00, 3, 1'b1, 18, 1'b0, 1);
    session("R8 collide",  1'b0, 2'b01, 2'b00, 0, 1'b1, 18, 1'b1, 1);
    session("R10 nostart", 1'b0, 2'b01, 2'b00, 0, 1'b0, 18, 1'b0, 0);
  endtask

  task automatic t_saturate;
    session("R9 write57", 1'b1, 2'b01, 2'b00, 0, 1'b1, 57, 1'b0, 2);
    session("R2 fresh after sat", 1'b1, 2'b11, 2'b00, 0, 1'b1, 9, 1'b0, 1);
  endtask

  initial begin
    t_reset();
    t_byte_lengths();
    t_word_lengths();
    t_misaligned();
    t_nonmod();
    t_start_and_collide();
    t_saturate();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule